// File: doc/BRIEF.md
# Exception Pending Control Register

This block is a single 32-bit memory-mapped control and status word for the system exceptions of a small processor's interrupt controller. It keeps the pending state of three exceptions: the non-maskable interrupt, a software-requested context-switch exception and a system-timer exception. Software makes an exception pending by writing 1 to its set bit. For the context-switch and timer exceptions, software removes the pending state by writing 1 to a separate clear bit, and that clear bit is write-only. The core clears a pending bit when it acknowledges entry to the matching handler.

The same word also shows several status values that the core drives: the active exception number, the highest-priority pending vector, an any-interrupt-pending flag, a preempted-active flag and a return-to-base flag. Only privileged accesses reach the register. An unprivileged access is refused, and the block raises a one-cycle error pulse for it.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset the three pending outputs are 0, `acc_err` is 0, and with all status inputs at 0 a privileged read of the register returns 0.
- R2: A privileged write with bit 31 = 1 makes the NMI pending, and a read shows that state in bit 31. A write with bit 31 = 0 leaves the NMI pending state unchanged.
- R3: A high `nmi_enter` clears the NMI pending state at the next edge. A rising edge on `nmi_req` sets it, including while the handler runs. When `nmi_req` is held high it does not set the state again. A set and an entry in the same cycle leave the state pending.
- R4: Writing 1 to bit 28 makes the context-switch exception pending, and a read returns that state in bit 28. Writing 1 to bit 27 removes the pending state. Bit 27 always reads 0. Nothing other than a bit-28 write makes this exception pending.
- R5: Writing 1 to bit 26 makes the timer exception pending, and a read returns that state in bit 26. Writing 1 to bit 25 removes the pending state. Bit 25 always reads 0.
- R6: When one access writes 1 to both the set bit and the clear bit of the same exception (28 with 27, or 26 with 25), the exception ends up pending.
- R7: A high `ctx_enter` or `tick_enter` clears the matching pending bit at the next edge. A set write in the same cycle wins, and the bit stays pending.
- R8: A read returns the status inputs in these fields:
  - `st_irq_pend` in bit 23;
  - `st_preempted` in bit 22;
  - `st_pend_vec` in bits 18:12;
  - `st_ret_base` in bit 11;
  - `st_active` in bits 6:0.
  Writes to these bits have no effect.
- R9: Bits 30:29, 27, 25, 24, 21:19 and 10:7 always read 0.
- R10: An access with `acc_priv` low changes no state, and while such a read is presented `acc_rdata` is 0. It raises `acc_err` for exactly the one cycle after the access. A privileged access never raises `acc_err`.
- R11: An access whose address differs from `REG_ADDR` changes no state, reads 0 and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Access address |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | Access is privileged |
| acc_rdata | output | 32 | Read data (combinational, 0 when not a valid privileged read of this register) |
| acc_err | output | 1 | One-cycle pulse after an unprivileged access to this register |
| nmi_req | input | 1 | NMI request level; a rising edge sets the NMI pending state |
| nmi_enter | input | 1 | Core enters the NMI handler |
| ctx_enter | input | 1 | Core enters the context-switch handler |
| tick_enter | input | 1 | Core enters the timer handler |
| st_active | input | 7 | Active exception number |
| st_pend_vec | input | 7 | Highest-priority pending exception number |
| st_irq_pend | input | 1 | Some interrupt is pending |
| st_preempted | input | 1 | Preempted exceptions are active |
| st_ret_base | input | 1 | Return-to-base indication |
| nmi_pending | output | 1 | NMI pending state |
| ctx_pending | output | 1 | Context-switch pending state |
| tick_pending | output | 1 | Timer pending state |

## Verification
The assertions rely on three conditions being true of the inputs:
- Every handler-entry input is a single-cycle pulse.
- `nmi_req` is a level whose edges are detected against its value in the previous cycle.
- Bus inputs change only between clock edges.

The bench keeps to these conditions. It drives every input on the falling edge and holds each entry pulse for exactly one cycle. It starts each new NMI edge only after `nmi_req` has been low for at least one cycle. It also holds `acc_en` low between accesses, so that each error pulse can be seen on its own.

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl #(
  parameter int          AW       = 12,
  parameter logic [11:0] REG_ADDR = 12'h104
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_wdata,
  input  logic          acc_priv,
  output logic [31:0]   acc_rdata,
  output logic          acc_err,
  input  logic          nmi_req,
  input  logic          nmi_enter,
  input  logic          ctx_enter,
  input  logic          tick_enter,
  input  logic [6:0]    st_active,
  input  logic [6:0]    st_pend_vec,
  input  logic          st_irq_pend,
  input  logic          st_preempted,
  input  logic          st_ret_base,
  output logic          nmi_pending,
  output logic          ctx_pending,
  output logic          tick_pending
);

  localparam logic [AW-1:0] HIT_ADDR  = AW'(REG_ADDR);
  localparam int            B_NMI     = 31;
  localparam int            B_CTX_SET = 28;
  localparam int            B_CTX_CLR = 27;
  localparam int            B_TCK_SET = 26;
  localparam int            B_TCK_CLR = 25;
  localparam logic [31:0]   RSVD_MASK = 32'h6B38_0780;

  logic hit, wr_ok, rd_ok, nmi_q, nmi_rise;
  logic nmi_set, ctx_set, ctx_clr, tck_set, tck_clr;

  assign hit      = acc_en && (acc_addr == HIT_ADDR);
  assign wr_ok    = hit && acc_wr && acc_priv;
  assign rd_ok    = hit && !acc_wr && acc_priv;
  assign nmi_rise = nmi_req && !nmi_q;

  assign nmi_set  = (wr_ok && acc_wdata[B_NMI]) || nmi_rise;
  assign ctx_set  = wr_ok && acc_wdata[B_CTX_SET];
  assign ctx_clr  = (wr_ok && acc_wdata[B_CTX_CLR]) || ctx_enter;
  assign tck_set  = wr_ok && acc_wdata[B_TCK_SET];
  assign tck_clr  = (wr_ok && acc_wdata[B_TCK_CLR]) || tick_enter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q        <= 1'b0;
      nmi_pending  <= 1'b0;
      ctx_pending  <= 1'b0;
      tick_pending <= 1'b0;
      acc_err      <= 1'b0;
    end else begin
      nmi_q        <= nmi_req;
      nmi_pending  <= nmi_set || (nmi_pending && !nmi_enter);
      ctx_pending  <= ctx_set || (ctx_pending && !ctx_clr);
      tick_pending <= tck_set || (tick_pending && !tck_clr);
      acc_err      <= hit && !acc_priv;
    end
  end

  assign acc_rdata = rd_ok ? {nmi_pending, 2'b00, ctx_pending, 1'b0, tick_pending, 2'b00,
                              st_irq_pend, st_preempted, 3'b000, st_pend_vec,
                              st_ret_base, 4'b0000, st_active} : 32'h0;

  AST_NMI_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_enter && !nmi_req && !(acc_en && acc_wr && acc_wdata[B_NMI])) |=> !nmi_pending); // R3

  AST_CTX_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctx_pending) |-> $past(acc_en && acc_wr && acc_priv && acc_addr == HIT_ADDR && acc_wdata[B_CTX_SET])); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_priv && acc_addr == HIT_ADDR && acc_wdata[B_TCK_SET] && acc_wdata[B_TCK_CLR])
    |=> tick_pending); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_enter && !(acc_en && acc_wr && acc_wdata[B_TCK_SET])) |=> !tick_pending); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rdata & RSVD_MASK) == 32'h0); // R9

  AST_UNPRIV_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_priv && acc_addr == HIT_ADDR) |=> acc_err); // R10

  AST_UNPRIV_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_priv) |-> acc_rdata == 32'h0); // R10

  AST_PRIV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_priv) |=> !acc_err); // R10

endmodule

// File: tb/test_exc_pend_ctrl.sv
module test_exc_pend_ctrl;
  localparam logic [11:0] RA = 12'h104;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_en = 0, acc_wr = 0, acc_priv = 1;
  logic [11:0] acc_addr = RA;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic acc_err;
  logic nmi_req = 0, nmi_enter = 0, ctx_enter = 0, tick_enter = 0;
  logic [6:0] st_active = 0, st_pend_vec = 0;
  logic st_irq_pend = 0, st_preempted = 0, st_ret_base = 0;
  logic nmi_pending, ctx_pending, tick_pending;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  exc_pend_ctrl i_exc_pend_ctrl (
    .clk, .rst_n, .acc_en, .acc_wr, .acc_addr, .acc_wdata, .acc_priv,
    .acc_rdata, .acc_err, .nmi_req, .nmi_enter, .ctx_enter, .tick_enter,
    .st_active, .st_pend_vec, .st_irq_pend, .st_preempted, .st_ret_base,
    .nmi_pending, .ctx_pending, .tick_pending);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 0; acc_wr = 0; acc_addr = RA; acc_priv = 1; acc_wdata = 0;
    nmi_enter = 0; ctx_enter = 0; tick_enter = 0;
  endtask

  task automatic wr(logic [31:0] d, logic priv = 1, logic [11:0] a = RA);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d; acc_priv = priv;
    idle();
  endtask

  task automatic rd(output logic [31:0] d, input logic priv = 1, input logic [11:0] a = RA);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a; acc_priv = priv;
    #1 d = acc_rdata;
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pending", {nmi_pending, ctx_pending, tick_pending}, 0);
    chk("R1 err", acc_err, 0);
    rd(d);
    chk("R1 read", d, 0);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    wr(32'h8000_0000);
    chk("R2 set", nmi_pending, 1);
    rd(d); chk("R2 readback", d[31], 1);
    wr(32'h0);
    chk("R2 write0", nmi_pending, 1);
    @(negedge clk); nmi_enter = 1; idle();
    chk("R3 entry clears", nmi_pending, 0);
    @(negedge clk); nmi_req = 1; @(negedge clk);
    chk("R3 rise sets", nmi_pending, 1);
    nmi_enter = 1; idle(); idle();
    chk("R3 held level no reset", nmi_pending, 0);
    nmi_req = 0; @(negedge clk); nmi_req = 1; @(negedge clk);
    chk("R3 reassert in handler", nmi_pending, 1);
    nmi_req = 0;
    nmi_enter = 1; acc_en = 1; acc_wr = 1; acc_wdata = 32'h8000_0000; idle();
    chk("R3 set beats entry", nmi_pending, 1);
    @(negedge clk); nmi_enter = 1; idle();
    chk("R3 cleared", nmi_pending, 0);
  endtask

  task automatic t_ctx();
    logic [31:0] d;
    wr(32'h1000_0000);
    chk("R4 set", ctx_pending, 1);
    rd(d); chk("R4 readback", d[28], 1); chk("R4 clr bit reads 0", d[27], 0);
    wr(32'h0800_0000);
    chk("R4 clear", ctx_pending, 0);
    wr(32'h1800_0000);
    chk("R6 ctx set wins", ctx_pending, 1);
    @(negedge clk); ctx_enter = 1; idle();
    chk("R7 ctx ack clears", ctx_pending, 0);
    @(negedge clk); ctx_enter = 1; acc_en = 1; acc_wr = 1; acc_wdata = 32'h1000_0000; idle();
    chk("R7 ctx set beats ack", ctx_pending, 1);
    wr(32'h0800_0000);
  endtask

  task automatic t_tick();
    logic [31:0] d;
    wr(32'h0400_0000);
    chk("R5 set", tick_pending, 1);
    rd(d); chk("R5 readback", d[26], 1); chk("R5 clr bit reads 0", d[25], 0);
    wr(32'h0200_0000);
    chk("R5 clear", tick_pending, 0);
    wr(32'h0600_0000);
    chk("R6 tick set wins", tick_pending, 1);
    @(negedge clk); tick_enter = 1; idle();
    chk("R7 tick ack clears", tick_pending, 0);
    @(negedge clk); tick_enter = 1; acc_en = 1; acc_wr = 1; acc_wdata = 32'h0400_0000; idle();
    chk("R7 tick set beats ack", tick_pending, 1);
    wr(32'h0200_0000);
  endtask

  task automatic t_status();
    logic [31:0] d;
    st_active = 7'h5A; st_pend_vec = 7'h33; st_irq_pend = 1; st_preempted = 0; st_ret_base = 1;
    rd(d);
    chk("R8 fields A", d, 32'h0083_3800 | 32'h5A);
    st_active = 7'h01; st_pend_vec = 7'h7F; st_irq_pend = 0; st_preempted = 1; st_ret_base = 0;
    wr(32'h00FF_FFFF);
    rd(d);
    chk("R8 fields B, writes ignored", d, 32'h0047_F001);
    wr(32'hFFFF_FFFF);
    rd(d);
    chk("R9 reserved zero", d & 32'h6B38_0780, 0);
    chk("R6 all sets win", d[31:24], 8'h94);
    @(negedge clk); nmi_enter = 1; idle();
    wr(32'h0A00_0000);
    st_active = 0; st_pend_vec = 0; st_preempted = 0;
  endtask

  task automatic t_priv();
    logic [31:0] d;
    wr(32'h1000_0000, 1'b0);
    chk("R10 err after unpriv write", acc_err, 1);
    chk("R10 unpriv write ignored", ctx_pending, 0);
    idle();
    chk("R10 err one cycle", acc_err, 0);
    wr(32'h0400_0000);
    rd(d, 1'b0);
    chk("R10 unpriv read zero", d, 0);
    chk("R10 err after unpriv read", acc_err, 1);
    wr(32'h0200_0000, 1'b0);
    chk("R10 unpriv clear ignored", tick_pending, 1);
    rd(d);
    chk("R10 priv no err", acc_err, 0);
    wr(32'h0200_0000);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(32'h9400_0000, 1'b1, RA + 12'h4);
    chk("R11 other addr write", {nmi_pending, ctx_pending, tick_pending}, 0);
    chk("R11 no err", acc_err, 0);
    st_irq_pend = 1;
    rd(d, 1'b1, RA - 12'h4);
    chk("R11 other addr read", d, 0);
    st_irq_pend = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        t_reset(); t_nmi(); t_ctx(); t_tick(); t_status(); t_priv(); t_addr();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule